// File: doc/BRIEF.md
# Serial SRAM SPI Host Engine

This block is the host side of a link to an SPI serial SRAM. A client places one request on a valid/ready port. The request carries an operation, a start address and a byte count. The engine then lowers chip select and clocks out the command byte. For memory operations it follows with two address bytes. It then moves the data bytes one at a time through a write-data handshake or a read-data handshake. When the last byte is done it raises chip select again.

SCK is made from the system clock by a parameterized half-period divider and idles low (SPI mode 0). The host changes SI only while SCK is low, and it samples SO on each rising edge of SCK. Several bytes can run under a single chip-select assertion. This lets the client stream a whole page or a burst once the device has been put in that mode. The client switches the mode with a status-write request issued first. When the client is slow, the engine waits with SCK held low rather than dropping bytes.

Top module: `sramSpiHost`

## Requirements
- R1: After reset csN is 1, sck is 0, busy is 0, reqReady is 1, wrReady is 0 and rdValid is 0.
- R2: reqOp encodes 0 = memory read, 1 = memory write, 2 = status read, 3 = status write. A memory request sends command 0x03 (read) or 0x02 (write), then a 16-bit address whose bit 15 is 0 and whose bits 14:0 are reqAddr, high byte first. Every byte is sent MSB first.
- R3: SCK is low whenever csN is high. Each SCK high phase lasts exactly HALF_DIV clock cycles and each low phase lasts at least HALF_DIV cycles. mosi never changes while sck is high or in the cycle sck rises.
- R4: Read bytes are assembled MSB first from miso samples taken at the rising edges of SCK. Each byte is offered on rdData with rdValid. rdValid and rdData hold until rdReady is seen.
- R5: A memory request moves exactly max(reqLen,1) data bytes under one chip-select assertion, so a reqLen of 0 moves one byte.
- R6: While wrReady is high and wrValid is low, or while rdValid is high and rdReady is low, SCK stays low and no bit is transferred.
- R7: A status write sends command 0x01, then one byte taken from the write port with bits 5:1 forced to 0 and bits 7:6 and 0 passed through.
- R8: A status read sends command 0x05, then clocks in exactly one byte and returns it on the read port. reqLen is ignored.
- R9: busy rises the cycle after a request is accepted and falls in the same cycle that csN rises. reqReady is high only while the engine is idle.
- R10: Between two transactions csN stays high for at least 2*HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and accepting a request |
| reqOp | input | 2 | Operation code (see R2) |
| reqAddr | input | ADDR_W | Start byte address |
| reqLen | input | LEN_W | Data byte count for memory operations |
| wrData | input | 8 | Write byte |
| wrValid | input | 1 | Write byte present |
| wrReady | output | 1 | Engine waiting for a write byte |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | Read byte present |
| rdReady | input | 1 | Client takes the read byte |
| busy | output | 1 | Transaction in progress until chip select is released |
| csN | output | 1 | Chip select to the SRAM, active low |
| sck | output | 1 | Serial clock to the SRAM |
| mosi | output | 1 | Serial data to the SRAM |
| miso | input | 1 | Serial data from the SRAM |

## Verification
The bound checker checks the SCK timing contract on every cycle: idle-low clock, minimum half-period widths, SI held still around rising edges, and the minimum chip-select gap. On every cycle it also checks that the clock stays frozen during either handshake stall, that read data holds until taken, and that busy and chip select line up. Frame content needs the bench's scenarios together with its behavioural SRAM model. This covers command codes, address bytes with bit 15 cleared, masking of the status byte, exact byte counts (including a zero count and the ignored count on status reads) and read data returned MSB first.

// File: rtl/sramSpiPkg.sv
package sramSpiPkg;

  typedef enum logic [1:0] {
    OP_READ      = 2'd0,
    OP_WRITE     = 2'd1,
    OP_STATUS_RD = 2'd2,
    OP_STATUS_WR = 2'd3
  } hostOp_e;

  typedef enum logic [2:0] {
    LD_OPCODE,
    LD_ADDR_HI,
    LD_ADDR_LO,
    LD_FILL,
    LD_WR_BYTE
  } loadSel_e;

  // strobes from the sequencer to the shifter
  typedef struct packed {
    logic     capture;
    logic     load;
    loadSel_e loadSel;
    logic     sckRise;
    logic     sckFall;
    logic     csLow;
    logic     csHigh;
  } strobe_t;

  // status byte: bits 5:1 are forced low on the way out
  localparam logic [7:0] STATUS_KEEP = 8'hC1;

  function automatic logic [7:0] opcodeOf(input hostOp_e op);
    case (op)
      OP_READ:      return 8'h03;
      OP_WRITE:     return 8'h02;
      OP_STATUS_RD: return 8'h05;
      default:      return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/sramSpiDatapath.sv
module sramSpiDatapath
  import sramSpiPkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        wrData,
  input  logic              miso,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  output logic [7:0]        rdData
);

  localparam int ADDR_PAD = 16 - ADDR_W;

  logic [7:0]        txShift;
  logic [7:0]        rxShift;
  logic [7:0]        loadVal;
  logic [ADDR_W-1:0] addrQ;
  hostOp_e           opQ;
  logic [15:0]       addrWord;

  assign addrWord = {{ADDR_PAD{1'b0}}, addrQ};

  always_comb begin
    case (st.loadSel)
      LD_OPCODE:  loadVal = opcodeOf(hostOp_e'(reqOp));
      LD_ADDR_HI: loadVal = addrWord[15:8];
      LD_ADDR_LO: loadVal = addrWord[7:0];
      LD_WR_BYTE: loadVal = (opQ == OP_STATUS_WR) ? (wrData & STATUS_KEEP) : wrData;
      default:    loadVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      addrQ   <= '0;
      opQ     <= OP_READ;
      sck     <= 1'b0;
      csN     <= 1'b1;
    end else begin
      if (st.capture) begin
        addrQ <= reqAddr;
        opQ   <= hostOp_e'(reqOp);
      end
      if (st.load)         txShift <= loadVal;
      else if (st.sckFall) txShift <= {txShift[6:0], 1'b0};
      if (st.sckRise) begin
        rxShift <= {rxShift[6:0], miso};
        sck     <= 1'b1;
      end else if (st.sckFall) begin
        sck <= 1'b0;
      end
      if (st.csLow)       csN <= 1'b0;
      else if (st.csHigh) csN <= 1'b1;
    end
  end

  assign mosi   = txShift[7];
  assign rdData = rxShift;

endmodule

// File: rtl/sramSpiCtrl.sv
module sramSpiCtrl
  import sramSpiPkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  input  logic             rdReady,
  output logic             reqReady,
  output logic             wrReady,
  output logic             rdValid,
  output logic             busy,
  output strobe_t          st
);

  localparam int CNT_W = $clog2(2 * HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(2 * HALF_DIV - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_BYTE, S_WAIT_WR, S_WAIT_RD, S_END, S_GAP
  } state_e;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR_HI, PH_ADDR_LO, PH_DATA} phase_e;

  state_e           state, nextState;
  phase_e           phase;
  hostOp_e          opQ;
  hostOp_e          reqOpE;
  logic [LEN_W-1:0] remain;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] cnt;
  logic             halfDone, gapDone, opIsMem, opIsRead, lastByte;

  assign reqOpE   = hostOp_e'(reqOp);
  assign halfDone = (cnt == HALF_LAST);
  assign gapDone  = (cnt == GAP_LAST);
  assign opIsMem  = (opQ == OP_READ) || (opQ == OP_WRITE);
  assign opIsRead = (opQ == OP_READ) || (opQ == OP_STATUS_RD);
  assign lastByte = (remain == LEN_W'(1));

  always_comb begin
    st        = '0;
    st.loadSel = LD_FILL;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid) begin
        st.capture = 1'b1;
        st.load    = 1'b1;
        st.loadSel = LD_OPCODE;
        st.csLow   = 1'b1;
        nextState  = S_LOW;
      end
      S_LOW: if (halfDone) begin
        st.sckRise = 1'b1;
        nextState  = S_HIGH;
      end
      S_HIGH: if (halfDone) begin
        st.sckFall = 1'b1;
        nextState  = (bitCnt == 3'd7) ? S_BYTE : S_LOW;
      end
      S_BYTE: begin
        case (phase)
          PH_CMD: begin
            if (opIsMem) begin
              st.load = 1'b1; st.loadSel = LD_ADDR_HI; nextState = S_LOW;
            end else if (opQ == OP_STATUS_RD) begin
              st.load = 1'b1; st.loadSel = LD_FILL; nextState = S_LOW;
            end else begin
              nextState = S_WAIT_WR;
            end
          end
          PH_ADDR_HI: begin
            st.load = 1'b1; st.loadSel = LD_ADDR_LO; nextState = S_LOW;
          end
          PH_ADDR_LO: begin
            if (opQ == OP_WRITE) nextState = S_WAIT_WR;
            else begin
              st.load = 1'b1; st.loadSel = LD_FILL; nextState = S_LOW;
            end
          end
          default: begin
            if (opIsRead)      nextState = S_WAIT_RD;
            else if (lastByte) nextState = S_END;
            else               nextState = S_WAIT_WR;
          end
        endcase
      end
      S_WAIT_WR: if (wrValid) begin
        st.load = 1'b1; st.loadSel = LD_WR_BYTE; nextState = S_LOW;
      end
      S_WAIT_RD: if (rdReady) begin
        if (lastByte) nextState = S_END;
        else begin
          st.load = 1'b1; st.loadSel = LD_FILL; nextState = S_LOW;
        end
      end
      S_END: if (halfDone) begin
        st.csHigh = 1'b1;
        nextState = S_GAP;
      end
      default: if (gapDone) nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= PH_CMD;
      opQ    <= OP_READ;
      remain <= '0;
      bitCnt <= '0;
      cnt    <= '0;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
      if (st.capture) begin
        opQ    <= reqOpE;
        phase  <= PH_CMD;
        bitCnt <= '0;
        if (reqOpE == OP_STATUS_RD || reqOpE == OP_STATUS_WR || reqLen == '0)
          remain <= LEN_W'(1);
        else
          remain <= reqLen;
      end else if (st.sckFall) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (state == S_BYTE) begin
        case (phase)
          PH_CMD:     phase <= opIsMem ? PH_ADDR_HI : PH_DATA;
          PH_ADDR_HI: phase <= PH_ADDR_LO;
          PH_ADDR_LO: phase <= PH_DATA;
          default:    phase <= PH_DATA;
        endcase
      end
      if ((state == S_BYTE && phase == PH_DATA && !opIsRead) ||
          (state == S_WAIT_RD && rdReady))
        remain <= remain - 1'b1;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign wrReady  = (state == S_WAIT_WR);
  assign rdValid  = (state == S_WAIT_RD);
  assign busy     = (state != S_IDLE) && (state != S_GAP);

endmodule

// File: rtl/sramSpiHost.sv
module sramSpiHost
  import sramSpiPkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 15,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              busy,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  strobe_t strobes;

  sramSpiCtrl #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqLen   (reqLen),
    .wrValid  (wrValid),
    .rdReady  (rdReady),
    .reqReady (reqReady),
    .wrReady  (wrReady),
    .rdValid  (rdValid),
    .busy     (busy),
    .st       (strobes)
  );

  sramSpiDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (strobes),
    .reqOp   (reqOp),
    .reqAddr (reqAddr),
    .wrData  (wrData),
    .miso    (miso),
    .sck     (sck),
    .csN     (csN),
    .mosi    (mosi),
    .rdData  (rdData)
  );

endmodule

// File: rtl/sramSpiHostChk.sv
module sramSpiHostChk #(
  parameter int HALF_DIV = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       busy,
  input logic       wrValid,
  input logic       wrReady,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       csN,
  input logic       sck,
  input logic       mosi
);

  localparam int CW = $clog2(2 * HALF_DIV + 1) + 1;
  localparam logic [CW-1:0] SAT = CW'(2 * HALF_DIV);

  logic          sckQ, csQ;
  logic [CW-1:0] sckRun, csRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ   <= 1'b0;
      csQ    <= 1'b1;
      sckRun <= SAT;
      csRun  <= SAT;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      if (sck != sckQ)      sckRun <= CW'(1);
      else if (sckRun != SAT) sckRun <= sckRun + 1'b1;
      if (csN != csQ)       csRun <= CW'(1);
      else if (csRun != SAT)  csRun <= csRun + 1'b1;
    end
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R3
  sck_half_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sck != sckQ) |-> (sckRun >= CW'(HALF_DIV)));

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  // R6
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady && !wrValid) |=> !sck);

  // R6
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !sck);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !reqReady));

  // R9
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && csQ) |-> (csRun >= CW'(2 * HALF_DIV)));

endmodule

bind sramSpiHost sramSpiHostChk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busy     (busy),
  .wrValid  (wrValid),
  .wrReady  (wrReady),
  .rdValid  (rdValid),
  .rdReady  (rdReady),
  .rdData   (rdData),
  .csN      (csN),
  .sck      (sck),
  .mosi     (mosi)
);

// File: tb/sramSpiHost_tb.sv
`timescale 1ns/1ps
module sramSpiHost_tb;

  localparam int HALF_DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [14:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic [7:0]  wrData = '0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        rdReady = 1'b0;
  logic        busy, csN, sck, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sramSpiHost #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData),
    .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .busy(busy), .csN(csN), .sck(sck), .mosi(mosi),
    .miso(miso)
  );

  // ---------------- behavioural serial SRAM ----------------
  logic [7:0]  devMem [256];
  logic [7:0]  statusReg = 8'h00;
  logic [7:0]  shiftIn = 8'h00;
  logic [7:0]  opSeen = 8'h00;
  logic [15:0] addrSeen = 16'h0000;
  int          bitIdx = 0;
  int          dataBytes = 0;

  always @(posedge sck or posedge csN) begin
    if (csN) begin
      bitIdx = 0;
    end else begin
      int byteIdx;
      shiftIn = {shiftIn[6:0], mosi};
      bitIdx++;
      if (bitIdx % 8 == 0) begin
        byteIdx = bitIdx / 8 - 1;
        if (byteIdx == 0) begin
          opSeen = shiftIn;
          dataBytes = 0;
        end else if ((opSeen == 8'h02 || opSeen == 8'h03) && byteIdx == 1) begin
          addrSeen[15:8] = shiftIn;
        end else if ((opSeen == 8'h02 || opSeen == 8'h03) && byteIdx == 2) begin
          addrSeen[7:0] = shiftIn;
        end else if (opSeen == 8'h02) begin
          devMem[8'(addrSeen + 16'(byteIdx - 3))] = shiftIn;
          dataBytes++;
        end else if (opSeen == 8'h01 && byteIdx == 1) begin
          statusReg = shiftIn;
          dataBytes++;
        end else begin
          dataBytes++;
        end
      end
    end
  end

  always @(negedge sck) begin
    if (!csN) begin
      if (opSeen == 8'h03 && bitIdx >= 24) begin
        int k;
        k = bitIdx - 24;
        miso = devMem[8'(addrSeen + 16'(k / 8))][7 - (k % 8)];
      end else if (opSeen == 8'h05 && bitIdx >= 8 && bitIdx < 16) begin
        miso = statusReg[7 - (bitIdx - 8)];
      end
    end
  end

  // ---------------- pin monitor ----------------
  logic sckPrev = 1'b0, mosiPrev = 1'b0, csPrev = 1'b1;
  int   runSck = 0, runCs = 0;
  int   minHi = 1000000, minLo = 1000000, minGap = 1000000;
  bit   seenFall = 0, mosiBad = 0, busyBad = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sck == sckPrev) runSck++;
      else begin
        if (sckPrev && runSck < minHi) minHi = runSck;
        if (!sckPrev && runSck < minLo) minLo = runSck;
        runSck = 1;
      end
      if (sck && mosi != mosiPrev) mosiBad = 1;
      if (csN == csPrev) runCs++;
      else begin
        if (!csN && seenFall && runCs < minGap) minGap = runCs;
        if (!csN) seenFall = 1;
        runCs = 1;
      end
      if (!busy && !csN) busyBad = 1;
    end
    sckPrev = sck; mosiPrev = mosi; csPrev = csN;
  end

  // ---------------- helpers ----------------
  task automatic checkEq(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expOpcode(input logic [1:0] op);
    case (op)
      2'd0: return 8'h03;
      2'd1: return 8'h02;
      2'd2: return 8'h05;
      default: return 8'h01;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0]  op;
    logic [14:0] addr;
    logic [7:0]  len;
    logic [7:0]  seed;
    logic [3:0]  stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 15'h0000, 8'd0, 8'hFF, 4'd0},  // R7 status write, masked
    '{2'd1, 15'h0010, 8'd1, 8'h5A, 4'd0},  // R2 single write
    '{2'd1, 15'h7FF0, 8'd4, 8'hA0, 4'd3},  // R5 R6 stream write, stalled
    '{2'd0, 15'h0010, 8'd1, 8'h5A, 4'd0},  // R4 single read
    '{2'd0, 15'h7FF0, 8'd4, 8'hA0, 4'd2},  // R4 R5 R6 stream read, stalled
    '{2'd2, 15'h0000, 8'd5, 8'hC1, 4'd0},  // R8 status read, count ignored
    '{2'd1, 15'h0100, 8'd0, 8'h33, 4'd0},  // R5 zero count write
    '{2'd0, 15'h0100, 8'd0, 8'h33, 4'd0}   // R5 zero count read
  };

  logic [7:0] rdGot [16];

  task automatic runTxn(input vec_t v);
    int  n;
    int  extra;
    bit  stallBad;
    logic [7:0] held;
    bit  isWr;
    isWr = (v.op == 2'd1) || (v.op == 2'd3);
    n = v.op[1] ? 1 : ((v.len == 0) ? 1 : int'(v.len));
    @(negedge clk);
    reqValid = 1'b1; reqOp = v.op; reqAddr = v.addr; reqLen = 16'(v.len);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R9 busy after accept", {30'd0, busy, reqReady}, 32'h2);
    for (int i = 0; i < n; i++) begin
      stallBad = 0;
      if (isWr) begin
        while (!wrReady) @(negedge clk);
        for (int s = 0; s < int'(v.stall); s++) begin
          @(negedge clk);
          if (sck || !wrReady) stallBad = 1;
        end
        if (v.stall != 0) checkEq("R6 write stall keeps sck low", 32'(stallBad), 32'd0);
        wrValid = 1'b1; wrData = v.seed + 8'(i);
        @(negedge clk);
        wrValid = 1'b0;
      end else begin
        while (!rdValid) @(negedge clk);
        held = rdData;
        for (int s = 0; s < int'(v.stall); s++) begin
          @(negedge clk);
          if (sck || !rdValid || rdData != held) stallBad = 1;
        end
        if (v.stall != 0) checkEq("R6 read stall keeps sck low", 32'(stallBad), 32'd0);
        rdGot[i] = rdData;
        rdReady = 1'b1;
        @(negedge clk);
        rdReady = 1'b0;
      end
    end
    extra = 0;
    while (busy) begin
      @(negedge clk);
      if (rdValid || wrReady) extra++;
    end
    checkEq("R5 no handshake beyond count", 32'(extra), 32'd0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 reset outputs", {26'd0, csN, sck, busy, reqReady, wrReady, rdValid},
            {26'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

    for (int vi = 0; vi < NVEC; vi++) begin
      vec_t v;
      int n;
      v = VECS[vi];
      n = v.op[1] ? 1 : ((v.len == 0) ? 1 : int'(v.len));
      runTxn(v);
      checkEq("R2 R7 R8 command byte", 32'(opSeen), 32'(expOpcode(v.op)));
      if (!v.op[1]) begin
        checkEq("R2 address bytes, bit 15 zero", 32'(addrSeen), {16'd0, 1'b0, v.addr});
      end
      checkEq("R5 R8 data byte count", 32'(dataBytes), 32'(n));
      case (v.op)
        2'd1: for (int i = 0; i < n; i++)
                checkEq("R2 written byte", 32'(devMem[8'(16'(v.addr) + 16'(i))]), 32'(v.seed + 8'(i)));
        2'd3: checkEq("R7 status byte masked", 32'(statusReg), 32'(v.seed & 8'hC1));
        2'd0: for (int i = 0; i < n; i++)
                checkEq("R4 read byte", 32'(rdGot[i]), 32'(v.seed + 8'(i)));
        default: checkEq("R8 status read value", 32'(rdGot[0]), 32'(v.seed));
      endcase
    end

    // R3 clock shape, R9 busy/cs, R10 gap
    checkEq("R3 sck high width", 32'(minHi), 32'(HALF_DIV));
    checkEq("R3 sck low width ok", 32'(minLo >= HALF_DIV), 32'd1);
    checkEq("R3 mosi still while sck high", 32'(mosiBad), 32'd0);
    checkEq("R9 busy low only with cs high", 32'(busyBad), 32'd0);
    checkEq("R10 cs gap ok", 32'(minGap >= 2 * HALF_DIV), 32'd1);
    checkEq("R1 idle after run", {30'd0, csN, sck}, 32'h2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule